// File: doc/BRIEF.md
# Stereo Serial Audio Transmit Channel

This block is one stereo transmit lane of a serial audio port. Software writes a left sample and then a right sample through a small register interface. The right-sample write pushes the pair into a FIFO. A serializer runs on the system clock and follows an externally supplied bit clock and word select. It sends each word MSB-first on the serial data line, left while word select is low and right while it is high. The first bit of a word goes out one bit clock after word select changes.

Registers set the number of valid bits per sample, a FIFO trigger level, three enable bits and an interrupt mask. The lane reports a FIFO-empty condition and a sticky overrun condition. Software clears the overrun by reading a dedicated register. A flush register empties the FIFO.

The serializer is a four-state machine. OFF is entered whenever any enable is low. OFF moves to HUNT once all enables are set. HUNT moves to LEFT_WORD at the first word start with word select low, and that move pops a pair. LEFT_WORD moves to RIGHT_WORD at a word start with word select high, and that move loads the held right sample. RIGHT_WORD moves back to LEFT_WORD at a word start with word select low, and that move pops the next pair. Between word starts, each falling bit clock edge shifts the word by one bit.

Top module: `i2s_tx_chan`

## Requirements
- R1: After reset the status register (address 6) reads 0x10: bit 4 (FIFO empty) is 1 and bit 5 (overrun) is 0. `irq` is 0 because the mask resets to both bits set, and `sd_out` is 0.
- R2: Writing address 0 holds a left sample. Writing address 1 pushes the held left sample and the written right sample as one pair. Pairs go out in write order, left while `ws_in` is low and right while it is high. Each word is 32 bit clocks long and is sent MSB-first. The MSB changes on the falling bit clock edge that follows the first rising edge at which the new `ws_in` level is seen.
- R3: The resolution register (address 3, bits 2:0) selects the number of valid bits. Code 2 selects 16 bits, code 4 selects 24 bits and code 5 selects 32 bits; any other code is treated as 32 bits. A sample is taken from its low bits and sent from its top valid bit down, and every later bit of the word is sent as 0.
- R4: The status empty bit (bit 4) is 1 exactly when the FIFO level is at or below the trigger register (address 4), which holds the threshold minus one.
- R5: A right-sample write while the FIFO holds DEPTH pairs discards the pair and sets overrun (status bit 5).
- R6: A read of address 7 returns the overrun flag in bit 0 and clears it. A read of the status register does not clear it.
- R7: Writing a value with bit 0 set to address 8 empties the FIFO.
- R8: Mask register (address 5) bit 4 masks the empty source and bit 5 masks the overrun source. `irq` is high when an unmasked source is set.
- R9: The lane sends data only when the enable register (address 2) has bit 0 (global), bit 1 (transmitter block) and bit 2 (channel) all set. Otherwise `sd_out` stays 0 and the FIFO is not read.
- R10: If the FIFO is empty when a left word starts, both words of that frame are sent as zeros.
- R11: Register reads return data one clock after the read strobe. Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid one clock after `reg_rd` |
| sck_in | input | 1 | External bit clock |
| ws_in | input | 1 | External word select, 0 for left |
| sd_out | output | 1 | Serial data out |
| irq | output | 1 | Interrupt, high when an unmasked source is set |

## Verification
The assertions rely on three properties of the inputs. The bit clock must be slow enough against `clk` that each half period spans several system cycles. Word select must change only on falling bit clock edges. A read and a right-sample write must not both target the overrun path in the same cycle. The stimulus holds each bit clock half for at least five system cycles and moves word select only together with the bit clock falling edge. It drives one register strobe at a time. Register writes that change the FIFO happen with the bit clock stopped, so the expected FIFO contents stay deterministic.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;

    typedef enum logic [1:0] {
        SER_OFF   = 2'd0,
        SER_HUNT  = 2'd1,
        SER_LEFT  = 2'd2,
        SER_RIGHT = 2'd3
    } ser_state_t;

    localparam logic [3:0] ADR_LEFT   = 4'd0;
    localparam logic [3:0] ADR_RIGHT  = 4'd1;
    localparam logic [3:0] ADR_ENABLE = 4'd2;
    localparam logic [3:0] ADR_RES    = 4'd3;
    localparam logic [3:0] ADR_TRIG   = 4'd4;
    localparam logic [3:0] ADR_MASK   = 4'd5;
    localparam logic [3:0] ADR_STATUS = 4'd6;
    localparam logic [3:0] ADR_OVRCLR = 4'd7;
    localparam logic [3:0] ADR_FLUSH  = 4'd8;

    // valid bits selected by a resolution code
    function automatic int res_bits(input logic [2:0] code);
        case (code)
            3'd2:    return 16;
            3'd4:    return 24;
            default: return 32;
        endcase
    endfunction

endpackage

// File: rtl/i2s_tx_fifo.sv
module i2s_tx_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 64,
    localparam int PW   = $clog2(DEPTH),
    localparam int LVLW = PW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic            pop,
    input  logic            flush,
    input  logic [W-1:0]    wdata,
    output logic [W-1:0]    rdata,
    output logic [LVLW-1:0] level,
    output logic            full,
    output logic            empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign full    = (level == LVLW'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign rdata   = mem[rp];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else if (flush) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            if (do_push && !do_pop)      level <= level + 1'b1;
            else if (do_pop && !do_push) level <= level - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

endmodule

// File: rtl/i2s_tx_regs.sv
module i2s_tx_regs
    import i2s_tx_pkg::*;
#(
    parameter int SW   = 32,
    parameter int LVLW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic            rd,
    input  logic [3:0]      addr,
    input  logic [31:0]     wdata,
    input  logic [LVLW-1:0] level,
    input  logic            full,
    output logic [31:0]     rdata,
    output logic            push,
    output logic [2*SW-1:0] push_data,
    output logic            flush,
    output logic            en_all,
    output logic [2:0]      res_code,
    output logic [1:0]      mask,
    output logic            ovr,
    output logic            irq
);
    logic [SW-1:0]   left_hold;
    logic [2:0]      en;
    logic [LVLW-1:0] trig;
    logic            empty_flag;
    logic            ovr_read;

    assign push       = wr && (addr == ADR_RIGHT);
    assign push_data  = {left_hold, wdata[SW-1:0]};
    assign flush      = wr && (addr == ADR_FLUSH) && wdata[0];
    assign en_all     = &en;
    assign empty_flag = (level <= trig);
    assign ovr_read   = rd && (addr == ADR_OVRCLR);
    assign irq        = (empty_flag && !mask[0]) || (ovr && !mask[1]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_hold <= '0;
            en        <= '0;
            res_code  <= 3'd5;
            trig      <= '0;
            mask      <= 2'b11;
        end else if (wr) begin
            unique case (addr)
                ADR_LEFT:   left_hold <= wdata[SW-1:0];
                ADR_ENABLE: en        <= wdata[2:0];
                ADR_RES:    res_code  <= wdata[2:0];
                ADR_TRIG:   trig      <= wdata[LVLW-1:0];
                ADR_MASK:   mask      <= wdata[5:4];
                default:    ;
            endcase
        end
    end

    // set has priority over the read clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              ovr <= 1'b0;
        else if (push && full)   ovr <= 1'b1;
        else if (ovr_read)       ovr <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd) begin
            unique case (addr)
                ADR_ENABLE: rdata <= {29'd0, en};
                ADR_RES:    rdata <= {29'd0, res_code};
                ADR_TRIG:   rdata <= 32'(trig);
                ADR_MASK:   rdata <= {26'd0, mask, 4'd0};
                ADR_STATUS: rdata <= {26'd0, ovr, empty_flag, 4'd0};
                ADR_OVRCLR: rdata <= {31'd0, ovr};
                default:    rdata <= '0;
            endcase
        end
    end

endmodule

// File: rtl/i2s_tx_ser.sv
module i2s_tx_ser
    import i2s_tx_pkg::*;
#(
    parameter int SW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sck,
    input  logic            ws,
    input  logic            en_all,
    input  logic [2:0]      res_code,
    input  logic [2*SW-1:0] fifo_rdata,
    input  logic            fifo_empty,
    output logic            pop,
    output logic            sd
);
    ser_state_t    state_q, state_d;
    logic [2:0]    sck_q;
    logic [1:0]    ws_q;
    logic          ws_cur, ws_prev;
    logic          sck_rise, sck_fall, word_start;
    logic          load_left, load_right;
    logic [SW-1:0] shreg, right_hold;

    function automatic logic [SW-1:0] justify(input logic [SW-1:0] s,
                                              input logic [2:0] c);
        int            b;
        logic [SW-1:0] ones;
        b    = res_bits(c);
        if (b > SW) b = SW;
        ones = '1;
        return (s & (ones >> (SW - b))) << (SW - b);
    endfunction

    assign sck_rise   = sck_q[1] && !sck_q[2];
    assign sck_fall   = !sck_q[1] && sck_q[2];
    assign word_start = sck_fall && (ws_cur != ws_prev);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q   <= '0;
            ws_q    <= '0;
            ws_cur  <= 1'b0;
            ws_prev <= 1'b0;
        end else begin
            sck_q <= {sck_q[1:0], sck};
            ws_q  <= {ws_q[0], ws};
            if (sck_rise) begin
                ws_prev <= ws_cur;
                ws_cur  <= ws_q[1];
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SER_OFF:   state_d = SER_HUNT;
            SER_HUNT:  if (word_start && !ws_cur) state_d = SER_LEFT;
            SER_LEFT:  if (word_start &&  ws_cur) state_d = SER_RIGHT;
            SER_RIGHT: if (word_start && !ws_cur) state_d = SER_LEFT;
        endcase
        if (!en_all) state_d = SER_OFF;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SER_OFF;
        else        state_q <= state_d;
    end

    assign load_left  = (state_d == SER_LEFT)  && (state_q != SER_LEFT);
    assign load_right = (state_d == SER_RIGHT) && (state_q == SER_LEFT);
    assign pop        = load_left && !fifo_empty;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg      <= '0;
            right_hold <= '0;
        end else if (load_left) begin
            shreg      <= fifo_empty ? '0 : justify(fifo_rdata[2*SW-1:SW], res_code);
            right_hold <= fifo_empty ? '0 : fifo_rdata[SW-1:0];
        end else if (load_right) begin
            shreg <= justify(right_hold, res_code);
        end else if (sck_fall) begin
            shreg <= shreg << 1;
        end
    end

    always_comb begin
        unique case (state_q)
            SER_LEFT, SER_RIGHT: sd = shreg[SW-1];
            default:             sd = 1'b0;
        endcase
    end

endmodule

// File: rtl/i2s_tx_chan.sv
module i2s_tx_chan
    import i2s_tx_pkg::*;
#(
    parameter int SW    = 32,
    parameter int DEPTH = 8,
    localparam int LVLW = $clog2(DEPTH) + 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        sck_in,
    input  logic        ws_in,
    output logic        sd_out,
    output logic        irq
);
    logic            push, pop, flush, full, empty, en_all, ovr;
    logic [2*SW-1:0] push_data, fifo_rdata;
    logic [LVLW-1:0] level;
    logic [2:0]      res_code;
    logic [1:0]      mask;

    i2s_tx_regs #(.SW(SW), .LVLW(LVLW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
        .wdata(reg_wdata), .level(level), .full(full), .rdata(reg_rdata),
        .push(push), .push_data(push_data), .flush(flush), .en_all(en_all),
        .res_code(res_code), .mask(mask), .ovr(ovr), .irq(irq)
    );

    i2s_tx_fifo #(.DEPTH(DEPTH), .W(2*SW)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .flush(flush),
        .wdata(push_data), .rdata(fifo_rdata), .level(level), .full(full),
        .empty(empty)
    );

    i2s_tx_ser #(.SW(SW)) u_ser (
        .clk(clk), .rst_n(rst_n), .sck(sck_in), .ws(ws_in), .en_all(en_all),
        .res_code(res_code), .fifo_rdata(fifo_rdata), .fifo_empty(empty),
        .pop(pop), .sd(sd_out)
    );

endmodule

// File: rtl/i2s_tx_chan_chk.sv
module i2s_tx_chan_chk
    import i2s_tx_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int LVLW = $clog2(DEPTH) + 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            push,
    input logic            pop,
    input logic            full,
    input logic            flush,
    input logic            rd,
    input logic [3:0]      addr,
    input logic            ovr,
    input logic [LVLW-1:0] level,
    input logic            en_all,
    input logic            sd,
    input logic [1:0]      mask,
    input logic            irq
);
    AST_OVR_SET_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |=> ovr); // R5
    AST_FULL_PUSH_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> (level == $past(level))); // R5
    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVLW'(DEPTH)); // R5
    AST_OVR_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr == ADR_OVRCLR && !(push && full)) |=> !ovr); // R6
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (level == '0)); // R7
    AST_IRQ_ALL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == 2'b11) |-> !irq); // R8
    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !en_all |=> !sd); // R9
    AST_OFF_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
        !en_all |-> !pop); // R9
endmodule

bind i2s_tx_chan i2s_tx_chan_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .full(full),
    .flush(flush), .rd(reg_rd), .addr(reg_addr), .ovr(ovr), .level(level),
    .en_all(en_all), .sd(sd_out), .mask(mask), .irq(irq)
);

// File: tb/i2s_tx_chan_bench.sv
module i2s_tx_chan_bench;
    localparam int HALF = 6;
    localparam int WORD = 32;
    localparam int DEP  = 8;

    logic        clk = 1'b0;
    logic        rst_n, reg_wr, reg_rd, sck, ws;
    logic [3:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        sd, irq;

    always #10 clk = ~clk;

    i2s_tx_chan u_i2s_tx_chan (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sck_in(sck), .ws_in(ws), .sd_out(sd), .irq(irq)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [31:0] mql [0:15];
    logic [31:0] mqr [0:15];
    int mqn;
    logic [31:0] rxw [0:63];
    int rxn, rx_bits;
    logic rx_prev, rx_on;
    logic [31:0] rx_cur;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(input logic [31:0] s, input logic [2:0] code);
        int b;
        logic [31:0] m;
        b = (code == 3'd2) ? 16 : (code == 3'd4) ? 24 : 32;
        m = (b == 32) ? 32'hFFFF_FFFF : ((32'h1 << b) - 32'h1);
        return (s & m) << (32 - b);
    endfunction

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
    endtask

    task automatic push_pair(input logic [31:0] l, input logic [31:0] r);
        wr(4'd0, l);
        wr(4'd1, r);
        if (mqn < DEP) begin mql[mqn] = l; mqr[mqn] = r; mqn++; end
    endtask

    task automatic bitclk(input logic w);
        @(negedge clk); sck = 1'b0; ws = w;
        repeat (HALF - 1) @(negedge clk);
        if (rx_on) begin
            rx_cur = {rx_cur[30:0], sd};
            rx_bits++;
            if (rx_bits == WORD) begin rxw[rxn] = rx_cur; rxn++; rx_on = 1'b0; end
        end
        if (ws != rx_prev) begin
            rx_prev = ws;
            if (!ws || rxn > 0) begin rx_on = 1'b1; rx_bits = 0; end
        end
        sck = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic run_frames(input int n);
        rxn = 0; rx_on = 1'b0; rx_bits = 0; rx_prev = ws;
        for (int f = 0; f < n; f++) begin
            repeat (WORD) bitclk(1'b0);
            repeat (WORD) bitclk(1'b1);
        end
    endtask

    task automatic new_phase();
        wr(4'd2, 32'd0);
        wr(4'd8, 32'd1);
        wr(4'd4, 32'd0);
        mqn = 0;
    endtask

    // checks received words against the model queue (or all zero)
    task automatic check_stream(input logic [2:0] code, input int nfr, input bit silent, input string req);
        logic [31:0] e;
        int p;
        check(rxn == 2*nfr - 1, req, 32'(rxn), 32'(2*nfr - 1));
        for (int k = 0; k < rxn; k++) begin
            p = k / 2;
            if (silent || p >= mqn) e = 32'd0;
            else e = exp_word((k % 2) ? mqr[p] : mql[p], code);
            check(rxw[k] == e, req, rxw[k], e);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [2:0]  code;
        int          np;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
        sck = 1'b1; ws = 1'b1; rx_prev = 1'b1; rx_on = 1'b0; rxn = 0; mqn = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(4'd6, d);
        check(d == 32'h10, "R1 status", d, 32'h10);
        check(irq == 1'b0, "R1 irq", 32'(irq), 32'd0);
        check(sd == 1'b0, "R1 sd", 32'(sd), 32'd0);
        // R11 unused address reads 0
        rd(4'd12, d);
        check(d == 32'd0, "R11 unused address", d, 32'd0);
        repeat (2) bitclk(1'b1);

        // R2 R3 R10 directed 16-bit, FIFO runs empty afterwards
        new_phase();
        wr(4'd3, 32'd2);
        push_pair(32'hDEAD_8001, 32'h1234_7FFE);
        push_pair(32'h0000_A5A5, 32'hFFFF_0001);
        push_pair(32'h0000_0001, 32'h0000_8000);
        wr(4'd2, 32'd7);
        run_frames(5);
        check_stream(3'd2, 5, 1'b0, "R2 R3 R10 16-bit stream");

        // R3 24-bit and unlisted code
        new_phase();
        wr(4'd3, 32'd4);
        push_pair(32'hFF80_0001, 32'h007F_FFFF);
        wr(4'd2, 32'd7);
        run_frames(2);
        check_stream(3'd4, 2, 1'b0, "R3 24-bit");
        new_phase();
        wr(4'd3, 32'd7);
        push_pair(32'h8000_0001, 32'h7FFF_FFFE);
        wr(4'd2, 32'd7);
        run_frames(2);
        check_stream(3'd7, 2, 1'b0, "R3 unlisted code as 32-bit");

        // R4 trigger level
        new_phase();
        wr(4'd4, 32'd2);
        push_pair(32'd1, 32'd2);
        push_pair(32'd3, 32'd4);
        rd(4'd6, d);
        check(d[4] == 1'b1, "R4 level 2 at trigger 2", 32'(d[4]), 32'd1);
        push_pair(32'd5, 32'd6);
        rd(4'd6, d);
        check(d[4] == 1'b0, "R4 level 3 above trigger 2", 32'(d[4]), 32'd0);

        // R8 mask
        new_phase();
        wr(4'd5, 32'h20);
        @(negedge clk);
        check(irq == 1'b1, "R8 empty unmasked", 32'(irq), 32'd1);
        push_pair(32'd9, 32'd9);
        check(irq == 1'b0, "R8 not empty", 32'(irq), 32'd0);
        wr(4'd5, 32'h30);

        // R5 R6 overrun
        new_phase();
        wr(4'd3, 32'd5);
        wr(4'd5, 32'h10);
        for (int i = 0; i < DEP; i++) push_pair($urandom, $urandom);
        rd(4'd6, d);
        check(d[5] == 1'b0, "R5 no overrun at full", 32'(d[5]), 32'd0);
        push_pair(32'hBAD0_BAD0, 32'hBAD1_BAD1);
        rd(4'd6, d);
        check(d[5] == 1'b1, "R5 overrun set", 32'(d[5]), 32'd1);
        check(irq == 1'b1, "R8 overrun irq", 32'(irq), 32'd1);
        rd(4'd6, d);
        check(d[5] == 1'b1, "R6 status read keeps overrun", 32'(d[5]), 32'd1);
        rd(4'd7, d);
        check(d == 32'd1, "R6 clear register value", d, 32'd1);
        rd(4'd6, d);
        check(d[5] == 1'b0, "R6 overrun cleared", 32'(d[5]), 32'd0);
        wr(4'd5, 32'h30);
        wr(4'd2, 32'd7);
        run_frames(DEP + 1);
        check_stream(3'd5, DEP + 1, 1'b0, "R5 discarded pair not sent");

        // R7 flush
        new_phase();
        wr(4'd3, 32'd5);
        push_pair(32'hAAAA_AAAA, 32'h5555_5555);
        push_pair(32'h1111_1111, 32'h2222_2222);
        wr(4'd8, 32'd1);
        mqn = 0;
        rd(4'd6, d);
        check(d[4] == 1'b1, "R7 empty after flush", 32'(d[4]), 32'd1);
        wr(4'd2, 32'd7);
        run_frames(2);
        check_stream(3'd5, 2, 1'b1, "R7 nothing sent after flush");

        // R9 partial enables
        new_phase();
        wr(4'd3, 32'd5);
        wr(4'd4, 32'd1);
        push_pair(32'hCAFE_0001, 32'hCAFE_0002);
        push_pair(32'hCAFE_0003, 32'hCAFE_0004);
        for (int m = 0; m < 3; m++) begin
            wr(4'd2, 32'h7 & ~(32'h1 << m));
            run_frames(2);
            check_stream(3'd5, 2, 1'b1, "R9 partial enable silent");
            rd(4'd6, d);
            check(d[4] == 1'b0, "R9 FIFO not read", 32'(d[4]), 32'd0);
        end
        wr(4'd2, 32'd7);
        run_frames(3);
        check_stream(3'd5, 3, 1'b0, "R9 full enable sends");

        // R2 R3 random phases
        for (int ph = 0; ph < 5; ph++) begin
            new_phase();
            case ($urandom % 4)
                0: code = 3'd2;
                1: code = 3'd4;
                2: code = 3'd5;
                default: code = 3'd1;
            endcase
            wr(4'd3, 32'(code));
            np = 1 + int'($urandom % 6);
            for (int i = 0; i < np; i++) push_pair($urandom, $urandom);
            wr(4'd2, 32'd7);
            run_frames(np + 1);
            check_stream(code, np + 1, 1'b0, "R2 R3 random stream");
        end

        done = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule